// File: doc/BRIEF.md
# Playback Sample Byte Assembler

This block builds playback samples from a host that writes one byte at a time to an 8-bit data port. An internal tracker decides which byte lane of a 32-bit sample each write fills. The host selects 1, 2 or 4 bytes per sample. Once every byte of a sample is in place, the tracker stops, and any further writes are dropped.

The host commits the sample by reading the status register. That read returns the tracker position, a ready bit and an error bit. It also returns the tracker to the first byte. If the sample was complete, the read pushes it into the FIFO that feeds the DACs. If the FIFO is full, the sample is lost and the error bit is set. If the sample was incomplete, it is discarded. While power-down is asserted, the port accepts nothing and the tracker stays at the first byte.

Top module: `pcm_byte_packer`

## Requirements
- R1: After reset, the status byte reads 0x00 and fifo_push is low.
- R2: Each accepted write increments the next-byte field (status bits [1:0]) by one, until the last byte of the sample is written.
- R3: Byte lanes fill in this order: left low [7:0], left high [15:8], right low [23:16], right high [31:24]. Lanes that are not written are pushed as zero.
- R4: bytes_sel encodes the sample width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. After the last byte is written, the ready bit (status bit 2) is 1 and the next-byte field holds the last lane index.
- R5: Writes made after the sample is complete are ignored. They change neither the status nor the pushed data.
- R6: A status read with a complete sample and fifo_full low raises fifo_push for exactly one cycle, on the cycle after the read. fifo_data then carries the sample.
- R7: A status read while the sample is incomplete discards the partial sample and does not push. After any status read, the status byte shows next-byte 0 and ready 0.
- R8: A status read with a complete sample and fifo_full high does not push and sets the error bit (status bit 3). The error bit stays set until the next status read, which clears it.
- R9: While pdn is high, writes are ignored and the tracker is held at the first byte with ready 0.
- R10: When a write and a status read occur in the same cycle, the read takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdn | input | 1 | Power-down; holds the tracker idle |
| bytes_sel | input | 2 | Bytes per sample code |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | 8 | Data port write byte |
| stat_rd | input | 1 | Status register read strobe |
| stat_q | output | 8 | Status: [3] error, [2] ready, [1:0] next byte |
| fifo_full | input | 1 | FIFO cannot accept a push |
| fifo_push | output | 1 | One-cycle push strobe |
| fifo_data | output | 32 | Sample pushed to the FIFO |

## Verification
A tracker that goes wrong shows in the status byte on the cycle after the write that caused it. The next-byte field or the ready bit then differs from the count of accepted writes. Lane steering errors and leaked extra writes stay hidden until the commit. They show on fifo_data one cycle after the status read, so every commit is compared against the expected word. A lost or spurious push, or an error bit that fails to follow fifo_full, appears on fifo_push and status bit 3 within one cycle of the read.

// File: rtl/pcm_byte_packer.sv
module pcm_byte_packer #(
  parameter int BYTE_W  = 8,
  parameter int LANES   = 4,
  localparam int IDX_W  = $clog2(LANES),
  localparam int SAMP_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic [1:0]        bytes_sel,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic [7:0]        stat_q,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [SAMP_W-1:0] fifo_data
);

  logic [IDX_W-1:0]  idx;
  logic              done;
  logic              err;
  logic [SAMP_W-1:0] samp;
  logic [IDX_W-1:0]  last_idx;
  logic              take;

  always_comb begin
    case (bytes_sel)
      2'd0:    last_idx = '0;
      2'd1:    last_idx = IDX_W'(1);
      default: last_idx = IDX_W'(LANES - 1);
    endcase
  end

  assign take   = wr_en && !pdn && !stat_rd && !done;
  assign stat_q = 8'({err, done, idx});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      samp      <= '0;
      fifo_push <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_push <= 1'b0;
      if (stat_rd) begin
        idx  <= '0;
        done <= 1'b0;
        samp <= '0;
        err  <= done && fifo_full;
        if (done && !fifo_full) begin
          fifo_push <= 1'b1;
          fifo_data <= samp;
        end
      end else if (pdn) begin
        idx  <= '0;
        done <= 1'b0;
        samp <= '0;
      end else if (take) begin
        samp[idx*BYTE_W +: BYTE_W] <= wr_data;
        if (idx == last_idx) done <= 1'b1;
        else                 idx  <= idx + 1'b1;
      end
    end
  end

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pdn && !stat_rd && !stat_q[2]) |=>
      (stat_q[2] || stat_q[1:0] == $past(stat_q[1:0]) + 2'd1));

  p_hold_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[2] && !stat_rd && !pdn) |=> (stat_q[2] && $stable(stat_q[1:0])));

  p_push_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> ($past(stat_rd) && $past(stat_q[2]) && !$past(fifo_full)));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (stat_q[2:0] == 3'b000));

  p_full_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && stat_q[2] && fifo_full) |=> (stat_q[3] && !fifo_push));

  p_pdn_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> (stat_q[2:0] == 3'b000));

endmodule

// File: tb/sim_pcm_byte_packer.sv
module sim_pcm_byte_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdn = 1'b0;
  logic [1:0]  bytes_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        stat_rd = 1'b0;
  logic [7:0]  stat_q;
  logic        fifo_full = 1'b0;
  logic        fifo_push;
  logic [31:0] fifo_data;

  int runs = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pcm_byte_packer u0 (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .bytes_sel(bytes_sel),
    .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd), .stat_q(stat_q),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data)
  );

  // {bytes_sel, writes, bytes, exp_push, exp_data}
  localparam logic [69:0] VEC [7] = '{
    {2'd0, 3'd1, 32'h000000A5, 1'b1, 32'h000000A5},
    {2'd1, 3'd2, 32'h00003412, 1'b1, 32'h00003412},
    {2'd2, 3'd4, 32'h78563412, 1'b1, 32'h78563412},
    {2'd2, 3'd6, 32'h44332211, 1'b1, 32'h44332211},
    {2'd2, 3'd3, 32'h00CCBBAA, 1'b0, 32'h00000000},
    {2'd3, 3'd4, 32'hDDCCBBAA, 1'b1, 32'hDDCCBBAA},
    {2'd0, 3'd3, 32'h0000005A, 1'b1, 32'h0000005A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", 32'(stat_q), 32'h00);
    chk("R1 push", 32'(fifo_push), 32'h0);

    for (int k = 0; k < 7; k++) begin
      logic [1:0] bs;
      logic [2:0] nw;
      logic [31:0] by;
      int nb;
      bs = VEC[k][69:68]; nw = VEC[k][67:65]; by = VEC[k][64:33];
      nb = (bs == 2'd0) ? 1 : (bs == 2'd1) ? 2 : 4;
      bytes_sel = bs;
      for (int i = 0; i < int'(nw); i++) wr(i < 4 ? by[8*i +: 8] : 8'hEE);
      chk("R4 ready bit", 32'(stat_q[2]), 32'(int'(nw) >= nb));
      chk("R4/R5 next field", 32'(stat_q[1:0]),
          32'((int'(nw) >= nb) ? nb - 1 : int'(nw)));
      rd();
      chk("R6/R7 push", 32'(fifo_push), 32'(VEC[k][32]));
      if (VEC[k][32]) chk("R3/R5 data", fifo_data, VEC[k][31:0]);
      chk("R7 status after read", 32'(stat_q[2:0]), 32'h0);
    end

    // R2 stepwise advance
    bytes_sel = 2'd2;
    wr(8'h01); chk("R2 after one", 32'(stat_q[1:0]), 32'd1);
    wr(8'h02); chk("R2 after two", 32'(stat_q[1:0]), 32'd2);
    rd();
    chk("R7 partial no push", 32'(fifo_push), 32'h0);

    // R8 full at commit
    bytes_sel = 2'd1;
    wr(8'h11); wr(8'h22);
    fifo_full = 1'b1;
    rd();
    chk("R8 no push when full", 32'(fifo_push), 32'h0);
    chk("R8 error set", 32'(stat_q[3]), 32'h1);
    fifo_full = 1'b0;
    wr(8'h33);
    chk("R8 error held", 32'(stat_q[3]), 32'h1);
    rd();
    chk("R8 error cleared", 32'(stat_q[3]), 32'h0);
    chk("R7 partial dropped", 32'(fifo_push), 32'h0);

    // R9 power-down
    pdn = 1'b1;
    wr(8'h77); wr(8'h78);
    chk("R9 tracker held", 32'(stat_q), 32'h00);
    pdn = 1'b0;
    bytes_sel = 2'd0;
    wr(8'h9C);
    rd();
    chk("R9 no leak from pdn writes", fifo_data, 32'h0000009C);

    // R10 read and write in same cycle
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h66; stat_rd = 1'b1;
    @(negedge clk); wr_en = 1'b0; stat_rd = 1'b0;
    chk("R10 write dropped", 32'(stat_q), 32'h00);
    chk("R10 no push", 32'(fifo_push), 32'h0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule